// File: doc/BRIEF.md
# Drive Seek Result Status Tracker

This block sits beside a floppy-style disk controller's command sequencer. It keeps one result status byte and one present-track value for each drive unit. It turns four operations into the result bytes the host reads back: seek, recalibrate, sense drive state and sense interrupt state. The sequencer pulses one strobe per accepted command and supplies the selected unit, the head and the cylinder operand. The board supplies an equipped mask, a media-present mask and a write-protect mask, each with one bit per unit. A drive model sends back a completion pulse, tagged with the unit, when the physical movement has finished.

Seek and recalibrate build the unit's status byte straight away. When the unit can move, they also issue a seek request to the drive model. On completion the unit's present-track register takes the stored target and an interrupt pulse is raised. The result bytes leave through a valid/ready byte stream with a last-byte marker. While a result is still being drained, new command strobes are refused.

Top module: `seek_status_tracker`

## Requirements
- R1: After reset every unit's status byte is 0 and every present track is 0. No result byte is valid, and intr_o, int_clear_o and seek_req_o are low.
- R2: Every status byte and every drive-state byte carries the head in bit 2 and the unit number in bits 1:0. Both are taken at the time of the command.
- R3: Seek stores the cylinder operand as the unit's target and sets seek-end (0x20) in the status. A unit that is unequipped or has no media also gets not-ready (0x08) and abnormal-termination (0x40), and no seek request is made. Otherwise seek_req_o pulses for one cycle with the unit and the cylinder.
- R4: Recalibrate sets seek-end (0x20). An unequipped unit adds 0x08 and 0x40. An equipped unit without media adds only 0x08. Otherwise seek_req_o pulses with target cylinder 0.
- R5: A completion pulse loads the unit's present track with its stored target. intr_o is high for exactly the one cycle after the completion pulse.
- R6: Sense drive state returns one byte. If the unit is unequipped, bit 7 is set. If it is equipped, bit 3 is set, bit 4 is set when the present track is 0, bit 5 when media is present, and bit 6 when the unit is write-protected.
- R7: Sense interrupt state picks the lowest-numbered unit whose status is nonzero. It returns two bytes, the status byte first and that unit's present track second, and clears that unit's status.
- R8: If no unit has a nonzero status, sense interrupt state returns the single byte 0x80 and int_clear_o pulses for one cycle.
- R9: A result byte and res_last_o stay stable while res_valid_o is high and res_ready_i is low. res_last_o marks the final byte of a result.
- R10: Command strobes that arrive while res_valid_o is high are ignored. They change no status and issue no seek request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| equip_i | input | N_UNITS | Unit is fitted |
| media_i | input | N_UNITS | Unit has media loaded |
| wprot_i | input | N_UNITS | Unit media is write-protected |
| unit_i | input | UW | Selected unit |
| head_i | input | 1 | Selected head |
| cyl_i | input | TRK_W | Cylinder operand of a seek |
| cmd_seek_i | input | 1 | Seek strobe |
| cmd_recal_i | input | 1 | Recalibrate strobe |
| cmd_sds_i | input | 1 | Sense drive state strobe |
| cmd_sis_i | input | 1 | Sense interrupt state strobe |
| seek_done_i | input | 1 | Drive model completion pulse |
| seek_done_unit_i | input | UW | Unit that completed |
| seek_req_o | output | 1 | Seek request pulse to the drive model |
| seek_unit_o | output | UW | Unit of the seek request |
| seek_cyl_o | output | TRK_W | Target cylinder of the seek request |
| intr_o | output | 1 | Interrupt pulse on completion |
| int_clear_o | output | 1 | Interrupt-clear request |
| res_valid_o | output | 1 | Result byte valid |
| res_data_o | output | 8 | Result byte |
| res_last_o | output | 1 | Final byte of the result |
| res_ready_i | input | 1 | Consumer takes the byte |

## Verification
The bench uses the defaults: four units and 8-bit tracks. The equipped mask leaves unit 3 out, and unit 2 is fitted without media, so one run covers the missing-drive and empty-drive result codes as well as a ready drive. With four units, the interrupt scan can be made to step through units 1, 2 and 3 in turn and then run dry. It can also be made to hold several pending statuses at once, which shows that the lowest unit wins and that entries are cleared one at a time.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam logic [7:0] ST_IC  = 8'h40;
  localparam logic [7:0] ST_SE  = 8'h20;
  localparam logic [7:0] ST_NR  = 8'h08;
  localparam logic [7:0] RES_INVALID = 8'h80;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEEK,
    OP_RECAL,
    OP_SDS,
    OP_SIS
  } op_e;
endpackage

// File: rtl/sst_unit_regs.sv
module sst_unit_regs #(
  parameter int N_UNITS = 4,
  parameter int TRK_W   = 8,
  localparam int UW     = $clog2(N_UNITS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [UW-1:0]                 wr_unit_i,
  input  logic [7:0]                    wr_stat_i,
  input  logic [TRK_W-1:0]              wr_tgt_i,
  input  logic [N_UNITS-1:0]            clr_i,
  input  logic                          done_i,
  input  logic [UW-1:0]                 done_unit_i,
  output logic [N_UNITS-1:0][7:0]       stat_o,
  output logic [N_UNITS-1:0][TRK_W-1:0] trk_o
);
  logic [N_UNITS-1:0][TRK_W-1:0] tgt_q;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic sel_wr, sel_done;
    assign sel_wr   = wr_i && (wr_unit_i == UW'(u));
    assign sel_done = done_i && (done_unit_i == UW'(u));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_o[u] <= '0;
        tgt_q[u]  <= '0;
      end else if (sel_wr) begin
        stat_o[u] <= wr_stat_i;
        tgt_q[u]  <= wr_tgt_i;
      end else if (clr_i[u]) begin
        stat_o[u] <= '0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trk_o[u] <= '0;
      else if (sel_done) trk_o[u] <= tgt_q[u];
    end
  end
endmodule

// File: rtl/sst_result_builder.sv
module sst_result_builder
  import sst_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int TRK_W   = 8,
  localparam int UW     = $clog2(N_UNITS)
) (
  input  op_e                           op_i,
  input  logic [UW-1:0]                 unit_i,
  input  logic                          head_i,
  input  logic [TRK_W-1:0]              cyl_i,
  input  logic [N_UNITS-1:0]            equip_i,
  input  logic [N_UNITS-1:0]            media_i,
  input  logic [N_UNITS-1:0]            wprot_i,
  input  logic [N_UNITS-1:0][7:0]       stat_i,
  input  logic [N_UNITS-1:0][TRK_W-1:0] trk_i,
  output logic                          wr_o,
  output logic [7:0]                    wr_stat_o,
  output logic [TRK_W-1:0]              wr_tgt_o,
  output logic                          seek_o,
  output logic [N_UNITS-1:0]            clr_o,
  output logic                          int_clr_o,
  output logic                          load_o,
  output logic                          two_o,
  output logic [7:0]                    b0_o,
  output logic [7:0]                    b1_o
);
  logic [7:0] id_bits;
  logic       eq, md;
  logic       found;

  assign id_bits = {5'b0, head_i, 2'(unit_i)};
  assign eq      = equip_i[unit_i];
  assign md      = media_i[unit_i];

  always_comb begin
    wr_o      = 1'b0;
    wr_stat_o = id_bits | ST_SE;
    wr_tgt_o  = '0;
    seek_o    = 1'b0;
    clr_o     = '0;
    int_clr_o = 1'b0;
    load_o    = 1'b0;
    two_o     = 1'b0;
    b0_o      = '0;
    b1_o      = '0;
    found     = 1'b0;
    unique case (op_i)
      OP_SEEK: begin
        wr_o     = 1'b1;
        wr_tgt_o = cyl_i;
        if (!eq || !md) wr_stat_o = id_bits | ST_SE | ST_NR | ST_IC;
        else seek_o = 1'b1;
      end
      OP_RECAL: begin
        wr_o = 1'b1;
        if (!eq) wr_stat_o = id_bits | ST_SE | ST_NR | ST_IC;
        else if (!md) wr_stat_o = id_bits | ST_SE | ST_NR;
        else seek_o = 1'b1;
      end
      OP_SDS: begin
        load_o = 1'b1;
        b0_o   = id_bits;
        if (!eq) b0_o[7] = 1'b1;
        else begin
          b0_o[3] = 1'b1;
          b0_o[4] = (trk_i[unit_i] == '0);
          b0_o[5] = md;
          b0_o[6] = wprot_i[unit_i];
        end
      end
      OP_SIS: begin
        load_o = 1'b1;
        for (int u = 0; u < N_UNITS; u++) begin
          if (!found && stat_i[u] != '0) begin
            found    = 1'b1;
            clr_o[u] = 1'b1;
            b0_o     = stat_i[u];
            b1_o     = 8'(trk_i[u]);
          end
        end
        two_o = found;
        if (!found) begin
          b0_o      = RES_INVALID;
          int_clr_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    assert_clear_onehot_R7: assert ($onehot0(clr_o));
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_chk
    always_comb begin
      if (clr_o[u]) assert_clear_pending_R7: assert (stat_i[u] != '0);
    end
  end
endmodule

// File: rtl/sst_result_stream.sv
module sst_result_stream (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       two_i,
  input  logic [7:0] b0_i,
  input  logic [7:0] b1_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       last_o
);
  logic [7:0] nxt_q;
  logic       more_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      nxt_q   <= '0;
      more_q  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= b0_i;
      nxt_q   <= b1_i;
      more_q  <= two_i;
    end else if (valid_o && ready_i) begin
      if (more_q) begin
        data_o <= nxt_q;
        more_q <= 1'b0;
      end else begin
        valid_o <= 1'b0;
      end
    end
  end

  assign last_o = valid_o && !more_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !load_i |=> valid_o && $stable(data_o) && $stable(last_o));
endmodule

// File: rtl/seek_status_tracker.sv
module seek_status_tracker
  import sst_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int TRK_W   = 8,
  localparam int UW     = $clog2(N_UNITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] equip_i,
  input  logic [N_UNITS-1:0] media_i,
  input  logic [N_UNITS-1:0] wprot_i,
  input  logic [UW-1:0]      unit_i,
  input  logic               head_i,
  input  logic [TRK_W-1:0]   cyl_i,
  input  logic               cmd_seek_i,
  input  logic               cmd_recal_i,
  input  logic               cmd_sds_i,
  input  logic               cmd_sis_i,
  input  logic               seek_done_i,
  input  logic [UW-1:0]      seek_done_unit_i,
  output logic               seek_req_o,
  output logic [UW-1:0]      seek_unit_o,
  output logic [TRK_W-1:0]   seek_cyl_o,
  output logic               intr_o,
  output logic               int_clear_o,
  output logic               res_valid_o,
  output logic [7:0]         res_data_o,
  output logic               res_last_o,
  input  logic               res_ready_i
);
  op_e                           op;
  logic [N_UNITS-1:0][7:0]       stat;
  logic [N_UNITS-1:0][TRK_W-1:0] trk;
  logic                          wr, seek_go, int_clr, load, two;
  logic [7:0]                    wr_stat, b0, b1;
  logic [TRK_W-1:0]              wr_tgt;
  logic [N_UNITS-1:0]            clr;

  // busy stream blocks every new command
  always_comb begin
    op = OP_NONE;
    if (!res_valid_o) begin
      if (cmd_seek_i)       op = OP_SEEK;
      else if (cmd_recal_i) op = OP_RECAL;
      else if (cmd_sds_i)   op = OP_SDS;
      else if (cmd_sis_i)   op = OP_SIS;
    end
  end

  sst_result_builder #(.N_UNITS(N_UNITS), .TRK_W(TRK_W)) u_build (
    .op_i(op), .unit_i(unit_i), .head_i(head_i), .cyl_i(cyl_i),
    .equip_i(equip_i), .media_i(media_i), .wprot_i(wprot_i),
    .stat_i(stat), .trk_i(trk),
    .wr_o(wr), .wr_stat_o(wr_stat), .wr_tgt_o(wr_tgt), .seek_o(seek_go),
    .clr_o(clr), .int_clr_o(int_clr), .load_o(load), .two_o(two),
    .b0_o(b0), .b1_o(b1)
  );

  sst_unit_regs #(.N_UNITS(N_UNITS), .TRK_W(TRK_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr), .wr_unit_i(unit_i), .wr_stat_i(wr_stat), .wr_tgt_i(wr_tgt),
    .clr_i(clr), .done_i(seek_done_i), .done_unit_i(seek_done_unit_i),
    .stat_o(stat), .trk_o(trk)
  );

  sst_result_stream u_stream (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .two_i(two), .b0_i(b0), .b1_i(b1),
    .ready_i(res_ready_i),
    .valid_o(res_valid_o), .data_o(res_data_o), .last_o(res_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seek_req_o  <= 1'b0;
      seek_unit_o <= '0;
      seek_cyl_o  <= '0;
      intr_o      <= 1'b0;
      int_clear_o <= 1'b0;
    end else begin
      seek_req_o  <= seek_go;
      intr_o      <= seek_done_i;
      int_clear_o <= int_clr;
      if (seek_go) begin
        seek_unit_o <= unit_i;
        seek_cyl_o  <= wr_tgt;
      end
    end
  end

  assert_seek_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_SEEK |=> stat[$past(unit_i)][5]);

  assert_recal_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_RECAL && seek_go |=> seek_req_o && seek_cyl_o == '0);

  assert_invalid_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clear_o |-> res_valid_o && res_data_o == RES_INVALID && res_last_o);

  assert_no_cmd_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> !seek_req_o && $stable(stat));
endmodule

// File: tb/tb_seek_status_tracker.sv
module tb_seek_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N_UNITS = 4;
  localparam int TRK_W = 8;
  localparam int UW = 2;

  logic clk = 0, rst_ni = 0;
  logic [N_UNITS-1:0] equip = 4'b0111, media = 4'b0011, wprot = 4'b0010;
  logic [UW-1:0] unit = 0, done_unit = 0;
  logic head = 0;
  logic [TRK_W-1:0] cyl = 0;
  logic c_seek = 0, c_recal = 0, c_sds = 0, c_sis = 0, done = 0, ready = 0;
  logic seek_req, intr, int_clear, rvalid, rlast;
  logic [UW-1:0] seek_unit;
  logic [TRK_W-1:0] seek_cyl;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seek_status_tracker #(.N_UNITS(N_UNITS), .TRK_W(TRK_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .equip_i(equip), .media_i(media), .wprot_i(wprot),
    .unit_i(unit), .head_i(head), .cyl_i(cyl),
    .cmd_seek_i(c_seek), .cmd_recal_i(c_recal), .cmd_sds_i(c_sds), .cmd_sis_i(c_sis),
    .seek_done_i(done), .seek_done_unit_i(done_unit),
    .seek_req_o(seek_req), .seek_unit_o(seek_unit), .seek_cyl_o(seek_cyl),
    .intr_o(intr), .int_clear_o(int_clear),
    .res_valid_o(rvalid), .res_data_o(rdata), .res_last_o(rlast), .res_ready_i(ready)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 seek, 1 recal, 2 sds, 3 sis
  task automatic cmd(int kind, int u, logic h, logic [TRK_W-1:0] c);
    @(negedge clk);
    unit = UW'(u); head = h; cyl = c;
    c_seek = (kind == 0); c_recal = (kind == 1); c_sds = (kind == 2); c_sis = (kind == 3);
    @(negedge clk);
    c_seek = 0; c_recal = 0; c_sds = 0; c_sis = 0;
  endtask

  task automatic pop(string tag, logic [7:0] exp, logic exp_last);
    chk({tag, " valid"}, rvalid, 1);
    chk({tag, " data"}, rdata, exp);
    chk({tag, " last"}, rlast, exp_last);
    ready = 1;
    @(negedge clk);
    ready = 0;
  endtask

  task automatic t_reset_R1;
    chk("R1 valid", rvalid, 0);
    chk("R1 intr", intr, 0);
    chk("R1 seek_req", seek_req, 0);
    chk("R1 int_clear", int_clear, 0);
    cmd(3, 0, 0, 0);
    chk("R1 R8 int_clear", int_clear, 1);
    pop("R1 R8 empty scan", 8'h80, 1);
    chk("R8 int_clear pulse", int_clear, 0);
    chk("R1 drained", rvalid, 0);
  endtask

  task automatic t_sds_R6;
    cmd(2, 0, 0, 0); pop("R6 unit0", 8'h38, 1);
    cmd(2, 1, 1, 0); pop("R6 R2 unit1 head1", 8'h7D, 1);
    cmd(2, 2, 0, 0); pop("R6 unit2 no media", 8'h1A, 1);
    cmd(2, 3, 0, 0); pop("R6 unit3 missing", 8'h83, 1);
  endtask

  task automatic t_seek_good_R3_R5;
    cmd(0, 0, 0, 8'd5);
    chk("R3 seek_req", seek_req, 1);
    chk("R3 seek_unit", seek_unit, 0);
    chk("R3 seek_cyl", seek_cyl, 5);
    chk("R1 no result for seek", rvalid, 0);
    @(negedge clk);
    chk("R3 seek_req pulse", seek_req, 0);
    chk("R5 no intr before done", intr, 0);
    done = 1; done_unit = 0;
    @(negedge clk);
    done = 0;
    chk("R5 intr", intr, 1);
    @(negedge clk);
    chk("R5 intr pulse", intr, 0);
    cmd(2, 0, 0, 0); pop("R5 R6 track nonzero", 8'h28, 1);
    cmd(3, 0, 0, 0);
    chk("R7 no int_clear", int_clear, 0);
    pop("R7 status", 8'h20, 0);
    pop("R7 R5 track", 8'h05, 1);
    cmd(3, 0, 0, 0); pop("R7 cleared", 8'h80, 1);
  endtask

  task automatic t_scan_R4_R7;
    cmd(0, 2, 1, 8'd9);
    chk("R3 no media no seek", seek_req, 0);
    cmd(1, 3, 0, 0);
    chk("R4 missing no seek", seek_req, 0);
    cmd(1, 1, 0, 0);
    chk("R4 recal seek_req", seek_req, 1);
    chk("R4 recal unit", seek_unit, 1);
    chk("R4 recal cyl", seek_cyl, 0);
    cmd(3, 0, 0, 0); pop("R7 first unit1", 8'h21, 0); pop("R7 unit1 trk", 8'h00, 1);
    cmd(3, 0, 0, 0); pop("R3 R2 unit2 err", 8'h6E, 0); pop("R7 unit2 trk", 8'h00, 1);
    cmd(3, 0, 0, 0); pop("R4 unit3 missing", 8'h6B, 0); pop("R7 unit3 trk", 8'h00, 1);
    cmd(3, 0, 0, 0); pop("R8 all drained", 8'h80, 1);
    cmd(1, 2, 0, 0);
    chk("R4 no media no seek", seek_req, 0);
    cmd(3, 0, 0, 0); pop("R4 unit2 not ready only", 8'h2A, 0); pop("R7 trk", 8'h00, 1);
  endtask

  task automatic t_busy_R9_R10;
    cmd(2, 0, 0, 0);
    cmd(0, 1, 0, 8'd7);
    chk("R10 no seek_req", seek_req, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 held data", rdata, 8'h28);
      chk("R9 held last", rlast, 1);
    end
    pop("R9 byte", 8'h28, 1);
    cmd(3, 0, 0, 0); pop("R10 no status written", 8'h80, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset_R1();
    t_sds_R6();
    t_seek_good_R3_R5();
    t_scan_R4_R7();
    t_busy_R9_R10();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule